// File: doc/BRIEF.md
# Fractional-Rate Timestamp Counter

This block keeps a 64-bit timestamp that runs at a fixed nominal rate, whatever the frequency of the clock that drives it. A phase accumulator adds a programmable numerator on every cycle. Each time the sum reaches the programmable denominator, the accumulator gives back the denominator and the timestamp rises by one. Over time the timestamp therefore advances at `f_clk * num / den`. Software picks the pair so that this product comes out at 6.144 MHz for the clock frequency in use.

A slow reference strobe keeps long-term drift bounded. The strobe is already synchronous to `clk` and lasts one cycle. Every two strobes add 375 counts to an internal coarse target. On each strobe the fine count is compared with the new target. A count that is behind is loaded with the target. A count that is ahead is frozen until a later target passes it. The timestamp never moves backwards, and register traffic never stops it.

Software reaches the block through a 32-bit register port with a one-cycle read latency. Reading the low count word captures the high word at the same moment. A following read of the high word then returns a coherent 64-bit value.

Top module: `frac_tstamp`

## Requirements
- R1: While reset is held the count is 0 and the read data is 0. After reset the ratio registers read back 4 (numerator) and 25 (denominator).
- R2: Start from a ratio write and let k cycles pass with no reference strobe. The count then grows by exactly floor(k*num/den). This holds for every pair in use: 4/25, 8/25, 8/25's neighbours 192/625, 64/125, 384/1625, 256/1125, 768/1625 and 75/244.
- R3: With no reference strobe, the count rises by at most one per cycle. It never decreases.
- R4: The numerator register sits at byte offset 0x10 and the denominator at 0x14. A write stores all 32 bits, and the same 32 bits read back. Only bits [11:0] set the ratio.
- R5: A write to either ratio register clears the fractional accumulator to zero. The new ratio applies from the next cycle.
- R6: Reads return data one cycle after the request. Offset 0x00 returns count bits [31:0] and captures bits [63:32]. Offset 0x04 returns the captured word. Any unmapped offset returns 0.
- R7: The coarse target grows by 187 on odd-numbered strobes and by 188 on even-numbered ones, which is 375 per pair. A count below the new target takes the target's value on that strobe's clock edge.
- R8: A count above the new target stops advancing. It resumes only at a strobe whose target is not below it, and on that strobe it takes the target's value.
- R9: Register reads and writes never stop the count from advancing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that sets the count rate |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 5 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data, valid the cycle after regRdEn |
| refTick | input | 1 | One-cycle reference strobe, synchronous to clk |
| count | output | 64 | Current timestamp |

## Verification
The accumulator is run with eight ratio pairs, from the coarse 4/25 to the fine 768/1625 and 75/244. Each run lasts exactly two denominator periods after a write has cleared the accumulator. An exact count delta therefore separates a correct carry and wrap from an off-by-one compare or a fraction that survived the write. The reference strobe is tried three ways: with the count behind the target (it jumps), well ahead (it freezes), and again after the target has overtaken it (it resumes). This tells a jump apart from a hold and from a missed alternation of the 187/188 step. One ratio pair is written with a 12-bit field of 25 and different upper bits in each register. It gives one count per cycle only if just the low field sets the rate while all 32 bits read back.

// File: rtl/frac_tstamp_pkg.sv
package frac_tstamp_pkg;
  localparam int REG_W = 32;

  localparam logic [7:0] OFF_CNT_LO = 8'h00;
  localparam logic [7:0] OFF_CNT_HI = 8'h04;
  localparam logic [7:0] OFF_NUM    = 8'h10;
  localparam logic [7:0] OFF_DEN    = 8'h14;

  typedef struct packed {
    logic clearAcc;
  } ts_strobe_t;
endpackage

// File: rtl/frac_tstamp_ctrl.sv
module frac_tstamp_ctrl
  import frac_tstamp_pkg::*;
#(
  parameter int COUNT_W   = 64,
  parameter int ADDR_W    = 5,
  parameter int RESET_NUM = 4,
  parameter int RESET_DEN = 25
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData,
  input  logic [COUNT_W-1:0] count,
  output logic [REG_W-1:0]   numReg,
  output logic [REG_W-1:0]   denReg,
  output ts_strobe_t         strobe
);
  localparam int HI_W = COUNT_W - REG_W;

  logic selLo, selHi, selNum, selDen;
  logic [REG_W-1:0] hiSnap;

  assign selLo  = (regAddr == ADDR_W'(OFF_CNT_LO));
  assign selHi  = (regAddr == ADDR_W'(OFF_CNT_HI));
  assign selNum = (regAddr == ADDR_W'(OFF_NUM));
  assign selDen = (regAddr == ADDR_W'(OFF_DEN));

  // Any ratio write restarts the fraction.
  always_comb begin
    strobe = '0;
    strobe.clearAcc = regWrEn && (selNum || selDen);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      numReg <= REG_W'(RESET_NUM);
      denReg <= REG_W'(RESET_DEN);
    end else if (regWrEn) begin
      if (selNum) numReg <= regWrData;
      if (selDen) denReg <= regWrData;
    end
  end

  // Registered read path; a low-word read snapshots the high word.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdData <= '0;
      hiSnap    <= '0;
    end else if (regRdEn) begin
      if (selLo) begin
        regRdData <= count[REG_W-1:0];
        hiSnap    <= REG_W'(count[REG_W +: HI_W]);
      end else if (selHi) begin
        regRdData <= hiSnap;
      end else if (selNum) begin
        regRdData <= numReg;
      end else if (selDen) begin
        regRdData <= denReg;
      end else begin
        regRdData <= '0;
      end
    end
  end
endmodule

// File: rtl/frac_tstamp_dp.sv
module frac_tstamp_dp
  import frac_tstamp_pkg::*;
#(
  parameter int COUNT_W   = 64,
  parameter int RATIO_W   = 12,
  parameter int TICK_PAIR = 375
) (
  input  logic               clk,
  input  logic               rstN,
  input  ts_strobe_t         strobe,
  input  logic [RATIO_W-1:0] num,
  input  logic [RATIO_W-1:0] den,
  input  logic               refTick,
  output logic [COUNT_W-1:0] count
);
  localparam int ACC_W  = RATIO_W + 1;
  localparam int STEP_A = TICK_PAIR / 2;
  localparam int STEP_B = TICK_PAIR - STEP_A;

  logic [ACC_W-1:0]   acc, accSum;
  logic               carry;
  logic [COUNT_W-1:0] expected, expNext, countNext;
  logic               tickPhase, holding, holdNext;

  // Phase accumulator: with num <= den a single subtract keeps acc < den.
  assign accSum = acc + {1'b0, num};
  assign carry  = (accSum >= {1'b0, den});

  always_ff @(posedge clk) begin
    if (!rstN)               acc <= '0;
    else if (strobe.clearAcc) acc <= '0;
    else if (carry)          acc <= accSum - {1'b0, den};
    else                     acc <= accSum;
  end

  // Coarse target and fine-count realignment.
  always_comb begin
    expNext   = expected + (tickPhase ? COUNT_W'(STEP_B) : COUNT_W'(STEP_A));
    countNext = count;
    holdNext  = holding;
    if (refTick) begin
      if (count < expNext) begin
        countNext = expNext;
        holdNext  = 1'b0;
      end else if (count > expNext) begin
        holdNext  = 1'b1;
      end else begin
        countNext = count + COUNT_W'(carry);
        holdNext  = 1'b0;
      end
    end else if (!holding) begin
      countNext = count + COUNT_W'(carry);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count     <= '0;
      expected  <= '0;
      tickPhase <= 1'b0;
      holding   <= 1'b0;
    end else begin
      count   <= countNext;
      holding <= holdNext;
      if (refTick) begin
        expected  <= expNext;
        tickPhase <= ~tickPhase;
      end
    end
  end
endmodule

// File: rtl/frac_tstamp.sv
module frac_tstamp
  import frac_tstamp_pkg::*;
#(
  parameter int COUNT_W   = 64,
  parameter int ADDR_W    = 5,
  parameter int RATIO_W   = 12,
  parameter int RESET_NUM = 4,
  parameter int RESET_DEN = 25,
  parameter int TICK_PAIR = 375
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  input  logic               refTick,
  output logic [COUNT_W-1:0] count
);
  logic [REG_W-1:0] numReg, denReg;
  ts_strobe_t       strobe;

  frac_tstamp_ctrl #(
    .COUNT_W(COUNT_W), .ADDR_W(ADDR_W),
    .RESET_NUM(RESET_NUM), .RESET_DEN(RESET_DEN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .count(count), .numReg(numReg), .denReg(denReg), .strobe(strobe)
  );

  frac_tstamp_dp #(
    .COUNT_W(COUNT_W), .RATIO_W(RATIO_W), .TICK_PAIR(TICK_PAIR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .num(numReg[RATIO_W-1:0]), .den(denReg[RATIO_W-1:0]),
    .refTick(refTick), .count(count)
  );
endmodule

// File: rtl/frac_tstamp_chk.sv
module frac_tstamp_chk
  import frac_tstamp_pkg::*;
#(
  parameter int COUNT_W = 64,
  parameter int ADDR_W  = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic               regRdEn,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [31:0]        regWrData,
  input logic [31:0]        regRdData,
  input logic               refTick,
  input logic [COUNT_W-1:0] count,
  input logic [31:0]        numReg,
  input logic [31:0]        denReg
);
  // R3
  count_monotonic_chk: assert property (@(posedge clk) disable iff (!rstN)
    count >= $past(count));

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !refTick |=> (count - $past(count)) <= COUNT_W'(1));

  // R4
  num_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(OFF_NUM)) |=> numReg == $past(regWrData));

  // R4
  den_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(OFF_DEN)) |=> denReg == $past(regWrData));

  // R6
  low_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADDR_W'(OFF_CNT_LO)) |=> regRdData == $past(count[31:0]));

  // R6
  num_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && !regWrEn && regAddr == ADDR_W'(OFF_NUM)) |=> regRdData == $past(numReg));
endmodule

bind frac_tstamp frac_tstamp_chk #(.COUNT_W(COUNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
  .refTick(refTick), .count(count), .numReg(numReg), .denReg(denReg)
);

// File: tb/frac_tstamp_tb.sv
module frac_tstamp_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0, refTick = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [63:0] count;

  int checks = 0, failures = 0;
  bit done = 0, wentBack = 0;
  logic [63:0] prevCnt = '0;

  localparam logic [4:0] A_LO = 5'h00, A_HI = 5'h04, A_NUM = 5'h10, A_DEN = 5'h14, A_NONE = 5'h08;

  typedef struct packed {
    logic [31:0] fin;
    logic [11:0] num;
    logic [11:0] den;
    logic        refDiv;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'd38400000, 12'd4,   12'd25,   1'b0},
    '{32'd19200000, 12'd8,   12'd25,   1'b0},
    '{32'd20000000, 12'd192, 12'd625,  1'b0},
    '{32'd12000000, 12'd64,  12'd125,  1'b0},
    '{32'd26000000, 12'd384, 12'd1625, 1'b0},
    '{32'd27000000, 12'd256, 12'd1125, 1'b0},
    '{32'd13000000, 12'd768, 12'd1625, 1'b0},
    '{32'd20000000, 12'd75,  12'd244,  1'b1}
  };

  frac_tstamp u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .refTick(refTick), .count(count)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (rstN && count < prevCnt) wentBack = 1;
    prevCnt = count;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic regRead(input logic [4:0] a, output logic [31:0] d, output logic [63:0] cAt);
    @(negedge clk); regRdEn = 1; regAddr = a; cAt = count;
    @(negedge clk); regRdEn = 0; d = regRdData;
  endtask

  task automatic pulseTick();
    @(negedge clk); refTick = 1;
    @(negedge clk); refTick = 0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    logic [63:0] cAt, c0, held;
    int k;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(count == 0, "R1 count in reset", count, 0);
    check(regRdData == 0, "R1 read data in reset", regRdData, 0);
    rstN = 1;
    regRead(A_NUM, rd, cAt);
    check(rd == 4, "R1 numerator reset", rd, 4);
    regRead(A_DEN, rd, cAt);
    check(rd == 25, "R1 denominator reset", rd, 25);

    // R7: count behind target jumps to 187, then 375
    repeat (2) @(negedge clk);
    pulseTick();
    check(count == 187, "R7 first tick", count, 187);
    repeat (3) @(negedge clk);
    pulseTick();
    check(count == 375, "R7 second tick", count, 375);

    // R8: count runs ahead at one per cycle, then freezes
    regWrite(A_DEN, 32'd1);
    regWrite(A_NUM, 32'd1);
    repeat (600) @(negedge clk);
    @(negedge clk); refTick = 1; held = count;
    @(negedge clk); refTick = 0;
    check(count == held, "R8 hold on tick 3", count, held);
    repeat (20) @(negedge clk);
    check(count == held, "R8 still held", count, held);
    k = 3;
    while (k < 40) begin
      logic [63:0] tgt;
      k++;
      pulseTick();
      tgt = (64'd375 * 64'(k)) / 2;
      if (tgt < held) begin
        check(count == held, "R8 held below target", count, held);
      end else if (tgt > held) begin
        check(count == tgt, "R8 resume at target", count, tgt);
        break;
      end else begin
        check(count == held + 1, "R8 equal resumes", count, held + 1);
        break;
      end
    end
    c0 = count;
    repeat (10) @(negedge clk);
    check(count == c0 + 10, "R3 one per cycle after resume", count, c0 + 10);

    // R4: upper bits kept, low field sets ratio 25/25
    regWrite(A_NUM, 32'hABCDE019);
    regWrite(A_DEN, 32'h5A5A5019);
    c0 = count;
    repeat (50) @(negedge clk);
    check(count == c0 + 50, "R4 low field ratio 25/25", count, c0 + 50);
    regRead(A_NUM, rd, cAt);
    check(rd == 32'hABCDE019, "R4 numerator readback", rd, 32'hABCDE019);
    regRead(A_DEN, rd, cAt);
    check(rd == 32'h5A5A5019, "R4 denominator readback", rd, 32'h5A5A5019);

    // R6: count reads
    regRead(A_LO, rd, cAt);
    check(rd == cAt[31:0], "R6 low word", rd, cAt[31:0]);
    regRead(A_HI, rd, cAt);
    check(rd == 0, "R6 high snapshot", rd, 0);
    regRead(A_NONE, rd, cAt);
    check(rd == 0, "R6 unmapped offset", rd, 0);

    // R2, R5, R9: ratio table
    for (int i = 0; i < 8; i++) begin
      vec_t v;
      int kk;
      logic [63:0] c1;
      v = VECS[i];
      if (v.refDiv)
        check(64'(v.num) * 1220 == 64'(v.den) * 375, "R2 ratio vs divided reference",
              64'(v.num) * 1220, 64'(v.den) * 375);
      else
        check(64'(v.fin) * 64'(v.num) == 64'd6144000 * 64'(v.den), "R2 nominal rate",
              64'(v.fin) * 64'(v.num), 64'd6144000 * 64'(v.den));
      regWrite(A_DEN, 32'(v.den));
      regWrite(A_NUM, 32'(v.num));
      c0 = count;
      if (i == 1) begin regRdEn = 1; regAddr = A_LO; end
      kk = 2 * int'(v.den);
      repeat (kk) @(negedge clk);
      regRdEn = 0;
      c1 = count;
      check(c1 - c0 == 64'(2 * int'(v.num)),
            (i == 1) ? "R9 count during reads" : "R2 R5 count delta",
            c1 - c0, 64'(2 * int'(v.num)));
    end

    check(!wentBack, "R3 never decreases", 64'(wentBack), 0);
    finishRun();
  end
endmodule